// File: doc/BRIEF.md
# Buffered SPI Master Controller

This block is a single-master serial peripheral interface controller. It sits between a host and up to NSEL slave devices. The host places one byte in a transmit holding register. When the internal 8-bit shifter is free, the controller copies that byte into the shifter on its own and runs a full-duplex exchange. It drives the serial clock, the outgoing data line and one active-low select. It also shifts the incoming data line into the same shifter, so master and slave registers form one ring.

After eight clock pulses the byte that came back is copied into a receive holding register and a valid flag is raised. The host clears the flag by reading. To read from a slave, the host sends a dummy byte. Clock idle level and data edge come from two configuration bits. The serial clock half-period is a programmable number of system clocks. Every output is a flop clocked by the system clock.

Top module: `spi_host_ctrl`

## Requirements
- R1: Each transfer moves 8 bits both ways, MSB first. The byte the slave presented appears on `rx_data`, and the slave receives the byte written through `tx_data`.
- R2: While no transfer runs, `sclk` rests at `cfg_ckp` (0 gives low, 1 gives high). Each transfer produces exactly 16 `sclk` transitions, which is 8 pulses.
- R3: With `cfg_cke`=1, `mosi` carries bit 7 from the moment the select falls and changes only on active-to-idle `sclk` edges. With `cfg_cke`=0, `mosi` changes only on idle-to-active edges. In each case `miso` is sampled on the other edge type.
- R4: Every `sclk` half-period, counted from select assertion to the first edge and then between edges, lasts `cfg_div`+1 system clocks.
- R5: At most one `ss_n` bit is low at a time. Bit number `cfg_sel` is low exactly while `busy` is high, and all bits are high otherwise.
- R6: A write taken while the shifter is idle sets `tx_full` on the next edge. On the edge after that, the byte moves into the shifter: `busy` rises and `tx_full` clears. A write taken during a transfer waits in the holding register and starts by itself once the current transfer ends.
- R7: A write presented while `tx_full` is high is ignored. The held byte is the one sent.
- R8: When a transfer completes, `rx_data` is updated and `rx_valid` set. A `rx_rd` pulse clears `rx_valid` on the next edge.
- R9: `busy` stays high from the shifter load until the edge on which the received byte is latched. It falls on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ckp | input | 1 | Serial clock idle level |
| cfg_cke | input | 1 | Data edge select (1: data changes active-to-idle) |
| cfg_div | input | DIV_W | Half-period minus one, in system clocks |
| cfg_sel | input | SEL_W | Index of the slave to select |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Byte to send |
| tx_full | output | 1 | Transmit holding register occupied |
| rx_rd | input | 1 | Read strobe, clears rx_valid |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Unread received byte present |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slaves |
| miso | input | 1 | Serial data from the selected slave |
| ss_n | output | NSEL | Active-low slave selects |

## Verification
The edge and select properties assume that `cfg_ckp`, `cfg_cke`, `cfg_div` and `cfg_sel` stay constant from a write until the matching transfer has finished, because the checker compares `mosi` activity against the live mode pins. The bench changes configuration only when the controller is idle with an empty holding register, and it waits for completion before picking the next random mode, divider, select and byte pair. A bench slave model follows the same mode rules at the opposite clock phase, so that wrong edge choices show up as corrupted bytes in either direction.

// File: rtl/spi_host_pkg.sv
// Package: shared constants and types for the SPI host controller.
// Assumes a fixed 8-bit character; all other sizes are module parameters.
package spi_host_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_SHIFT = 1'b1
    } eng_state_t;

    typedef struct packed {
        logic ckp;   // serial clock idle level
        logic cke;   // 1: data changes on active-to-idle edge
    } spi_mode_t;
endpackage

// File: rtl/spi_rate_gen.sv
// Module: half-period tick generator for the serial clock.
// Latches the divider when a transfer starts and pulses tick every
// (div+1) system clocks while run is high. Assumes run rises the cycle
// after start.
module spi_rate_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div_q);

    // Capture the divider for the whole transfer and count half-periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (start) begin
            div_q <= div_in;
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_hold_regs.sv
// Module: transmit and receive holding registers.
// The transmit side accepts one byte when empty and releases it when the
// shifter takes it; the receive side stores each finished byte and keeps
// a valid flag until the host reads. Assumes take only when tx_full.
module spi_hold_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    input  logic         fin,
    input  logic [W-1:0] fin_word,
    input  logic         rd_en,
    output logic         tx_full,
    output logic [W-1:0] tx_word,
    output logic [W-1:0] rx_word,
    output logic         rx_valid
);
    // Transmit holding register: load when empty, empty on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_full <= 1'b0;
            tx_word <= '0;
        end else if (take) begin
            tx_full <= 1'b0;
        end else if (wr_en && !tx_full) begin
            tx_full <= 1'b1;
            tx_word <= wr_data;
        end
    end

    // Receive holding register: completion wins over a same-cycle read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else if (fin) begin
            rx_word  <= fin_word;
            rx_valid <= 1'b1;
        end else if (rd_en) begin
            rx_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_shift_eng.sv
// Module: shift engine. Loads a byte, drives select, clock and data for
// 2*BYTE_W half-periods and shifts the input line into the same register.
// Mode and select are frozen at start. fin and rx_word are combinational
// so the receive register latches on the edge where busy falls.
module spi_shift_eng
    import spi_host_pkg::*;
#(
    parameter int NSEL  = 4,
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  spi_mode_t         mode_in,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [NSEL-1:0]   ss_n,
    output logic              busy,
    output logic              fin,
    output logic [BYTE_W-1:0] rx_word
);
    localparam int NEDGE  = 2 * BYTE_W;
    localparam int EDGE_W = $clog2(NEDGE);

    eng_state_t          st_q;
    spi_mode_t           mode_q;
    logic [BYTE_W-1:0]   sh_q;
    logic                samp_q;
    logic [EDGE_W-1:0]   edge_q;
    logic [NSEL-1:0]     sel_dec;
    logic                lead;
    logic                last;
    logic                in_bit;

    // One-hot active-low decode of the requested slave.
    for (genvar g = 0; g < NSEL; g++) begin : g_dec
        assign sel_dec[g] = (sel_in != SEL_W'(g));
    end

    assign busy    = (st_q == ENG_SHIFT);
    assign lead    = ~edge_q[0];
    assign last    = (edge_q == EDGE_W'(NEDGE - 1));
    assign in_bit  = mode_q.cke ? samp_q : miso;
    assign fin     = busy && tick && last;
    assign rx_word = {sh_q[BYTE_W-2:0], in_bit};

    // Sequence the transfer: load, toggle clock, sample and shift, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ENG_IDLE;
            mode_q <= '0;
            sh_q   <= '0;
            samp_q <= 1'b0;
            edge_q <= '0;
            sclk   <= 1'b0;
            mosi   <= 1'b0;
            ss_n   <= '1;
        end else begin
            case (st_q)
                ENG_IDLE: begin
                    sclk <= mode_in.ckp;
                    if (start) begin
                        st_q   <= ENG_SHIFT;
                        mode_q <= mode_in;
                        sh_q   <= tx_byte;
                        edge_q <= '0;
                        ss_n   <= sel_dec;
                        if (mode_in.cke) begin
                            mosi <= tx_byte[BYTE_W-1];
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        sclk   <= ~sclk;
                        edge_q <= edge_q + 1'b1;
                        if (lead) begin
                            if (mode_q.cke) begin
                                samp_q <= miso;
                            end else begin
                                mosi <= sh_q[BYTE_W-1];
                            end
                        end else if (last) begin
                            st_q <= ENG_IDLE;
                            ss_n <= '1;
                        end else begin
                            sh_q <= {sh_q[BYTE_W-2:0], in_bit};
                            if (mode_q.cke) begin
                                mosi <= sh_q[BYTE_W-2];
                            end
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_host_ctrl.sv
// Module: top of the buffered SPI master. Ties the holding registers,
// rate generator and shift engine together. A held byte is started the
// first idle cycle it is present. Assumes configuration inputs are held
// steady from a write until the matching transfer completes.
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter  int NSEL  = 4,
    parameter  int DIV_W = 8,
    localparam int SEL_W = (NSEL > 1) ? $clog2(NSEL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ckp,
    input  logic              cfg_cke,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_full,
    input  logic              rx_rd,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NSEL-1:0]   ss_n
);
    logic              start;
    logic              tick;
    logic              fin;
    logic [BYTE_W-1:0] tx_word;
    logic [BYTE_W-1:0] fin_word;
    spi_mode_t         mode;

    assign mode  = '{ckp: cfg_ckp, cke: cfg_cke};
    assign start = tx_full && !busy;

    spi_hold_regs #(.W(BYTE_W)) hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tx_wr),
        .wr_data  (tx_data),
        .take     (start),
        .fin      (fin),
        .fin_word (fin_word),
        .rd_en    (rx_rd),
        .tx_full  (tx_full),
        .tx_word  (tx_word),
        .rx_word  (rx_data),
        .rx_valid (rx_valid)
    );

    spi_rate_gen #(.DIV_W(DIV_W)) rate_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .run    (busy),
        .div_in (cfg_div),
        .tick   (tick)
    );

    spi_shift_eng #(.NSEL(NSEL), .SEL_W(SEL_W)) eng_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_byte (tx_word),
        .mode_in (mode),
        .sel_in  (cfg_sel),
        .tick    (tick),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .ss_n    (ss_n),
        .busy    (busy),
        .fin     (fin),
        .rx_word (fin_word)
    );
endmodule

// File: rtl/spi_host_ctrl_chk.sv
// Module: property checker for spi_host_ctrl, bound to every instance.
// Assumes configuration inputs stay constant during a transfer.
module spi_host_ctrl_chk #(
    parameter int NSEL = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_ckp,
    input logic            cfg_cke,
    input logic            tx_full,
    input logic            rx_rd,
    input logic            rx_valid,
    input logic            busy,
    input logic            sclk,
    input logic            mosi,
    input logic [NSEL-1:0] ss_n
);
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ss_n) <= 1); // R5
    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&ss_n)); // R5
    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $past(rst_n)) |-> (sclk == $past(cfg_ckp))); // R2
    AST_MOSI_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(mosi)) |->
            (!$stable(sclk) && ((sclk == cfg_ckp) == cfg_cke))); // R3
    AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rx_valid); // R9
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !busy) |=> !rx_valid); // R8
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && busy) |=> tx_full); // R7
endmodule

bind spi_host_ctrl spi_host_ctrl_chk #(.NSEL(NSEL)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_ckp  (cfg_ckp),
    .cfg_cke  (cfg_cke),
    .tx_full  (tx_full),
    .rx_rd    (rx_rd),
    .rx_valid (rx_valid),
    .busy     (busy),
    .sclk     (sclk),
    .mosi     (mosi),
    .ss_n     (ss_n)
);

// File: tb/spi_host_ctrl_tb_top.sv
// Bench: random and directed transfers against a behavioural slave model.
module spi_host_ctrl_tb_top;
    localparam int NSEL  = 4;
    localparam int DIV_W = 8;
    localparam int SEL_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_ckp = 1'b0, cfg_cke = 1'b1;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [SEL_W-1:0] cfg_sel = '0;
    logic             tx_wr = 1'b0, rx_rd = 1'b0;
    logic [7:0]       tx_data = '0;
    logic             tx_full, rx_valid, busy, sclk, mosi;
    logic [7:0]       rx_data;
    logic             miso = 1'b0;
    logic [NSEL-1:0]  ss_n;

    int checks = 0, errors = 0;
    int cur_div = 0, cur_sel = 0;
    bit cur_ckp = 0, cur_cke = 1;
    logic [7:0] sl_byte = '0, sl_sh = '0, sl_rcv = '0;
    int edge_cnt = 0, hp_cnt = 0, hp_bad = 0, ss_viol = 0;
    logic prev_sclk = 1'b0, prev_low = 1'b0;

    always #5 clk = ~clk;

    spi_host_ctrl #(.NSEL(NSEL), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_ckp(cfg_ckp), .cfg_cke(cfg_cke),
        .cfg_div(cfg_div), .cfg_sel(cfg_sel), .tx_wr(tx_wr), .tx_data(tx_data),
        .tx_full(tx_full), .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid),
        .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    function automatic logic [NSEL-1:0] exp_ss(input int sel);
        return ~(NSEL'(1) << sel);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Slave model and link monitor, evaluated between clock edges.
    always @(negedge clk) begin
        if (rst_n) begin
            logic low;
            low = (ss_n[cur_sel] == 1'b0);
            if (low && !prev_low) begin
                sl_sh = sl_byte; sl_rcv = '0; hp_cnt = 0; edge_cnt = 0;
                if (cur_cke) miso = sl_byte[7];
            end else begin
                hp_cnt++;
                if (prev_low && sclk != prev_sclk) begin
                    edge_cnt++;
                    if (hp_cnt != cur_div + 1) hp_bad++;
                    hp_cnt = 0;
                    if (prev_sclk == cur_ckp) begin
                        if (cur_cke) sl_rcv = {sl_rcv[6:0], mosi};
                        else begin miso = sl_sh[7]; sl_sh = {sl_sh[6:0], 1'b0}; end
                    end else begin
                        if (cur_cke) begin miso = sl_sh[6]; sl_sh = {sl_sh[6:0], 1'b0}; end
                        else sl_rcv = {sl_rcv[6:0], mosi};
                    end
                end
            end
            if (busy ? (ss_n != exp_ss(cur_sel)) : (ss_n != '1)) ss_viol++;
            prev_low  = low;
            prev_sclk = sclk;
        end
    end

    task automatic set_cfg(input bit ckp, input bit cke, input int div, input int sel);
        @(negedge clk);
        cfg_ckp = ckp; cfg_cke = cke; cfg_div = DIV_W'(div); cfg_sel = SEL_W'(sel);
        cur_ckp = ckp; cur_cke = cke; cur_div = div; cur_sel = sel;
        hp_bad = 0; ss_viol = 0;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk); tx_data = d; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic wait_rx();
        while (!rx_valid) @(negedge clk);
        #1;
    endtask

    task automatic rd_pulse();
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
        chk(rx_valid == 1'b0, "R8 read clears rx_valid", rx_valid, 0);
    endtask

    task automatic xfer(input bit ckp, input bit cke, input int div, input int sel,
                        input logic [7:0] tx, input logic [7:0] sb);
        set_cfg(ckp, cke, div, sel);
        sl_byte = sb;
        @(negedge clk);
        chk(sclk == ckp, "R2 idle sclk level", sclk, ckp);
        tx_data = tx; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        chk(tx_full && !busy, "R6 held before load", {tx_full, busy}, 2'b10);
        @(negedge clk);
        chk(busy && !tx_full, "R6 auto load", {tx_full, busy}, 2'b01);
        if (cke) chk(mosi == tx[7], "R3 first bit before first edge", mosi, tx[7]);
        wait_rx();
        chk(!busy, "R9 busy low when byte latched", busy, 0);
        chk(rx_data == sb, "R1 received byte", rx_data, sb);
        chk(sl_rcv == tx, "R3 slave got byte", sl_rcv, tx);
        chk(edge_cnt == 16, "R2 edge count", edge_cnt, 16);
        chk(hp_bad == 0, "R4 half-period", hp_bad, 0);
        chk(ss_viol == 0, "R5 select pattern", ss_viol, 0);
        rd_pulse();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ss_n == '1, "R5 reset deselect", ss_n, 4'hF);
        chk(!busy && !tx_full, "R6 reset idle", {tx_full, busy}, 0);
        chk(!rx_valid, "R8 reset rx_valid", rx_valid, 0);

        // Directed corners: all four modes at fastest rate, extreme patterns.
        xfer(0, 1, 0, 0, 8'hA5, 8'h5A);
        xfer(0, 0, 0, 1, 8'hFF, 8'h00);
        xfer(1, 1, 0, 2, 8'h00, 8'hFF);
        xfer(1, 0, 0, 3, 8'h81, 8'h7E);
        xfer(1, 1, 9, 1, 8'h3C, 8'hC3);

        // Queued write and ignored write while the holding register is full.
        set_cfg(0, 1, 3, 1);
        sl_byte = 8'h11;
        wr_byte(8'hA1);
        while (!busy) @(negedge clk);
        wr_byte(8'hB2);
        wr_byte(8'hC3);
        chk(tx_full, "R7 holding register kept", tx_full, 1);
        wait_rx();
        chk(sl_rcv == 8'hA1, "R6 first queued byte", sl_rcv, 8'hA1);
        sl_byte = 8'h22;
        rd_pulse();
        while (!busy) @(negedge clk);
        wait_rx();
        chk(sl_rcv == 8'hB2, "R7 ignored write not sent", sl_rcv, 8'hB2);
        chk(rx_data == 8'h22, "R1 second received byte", rx_data, 8'h22);
        rd_pulse();
        repeat (100) @(negedge clk);
        chk(!busy && !tx_full, "R7 no extra transfer", {tx_full, busy}, 0);

        // Constrained random transfers.
        for (int i = 0; i < 40; i++) begin
            xfer(1'($urandom % 2), 1'($urandom % 2), int'($urandom % 4),
                 int'($urandom % NSEL), 8'($urandom), 8'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule